// File: doc/BRIEF.md
# Serial-Triggered Sample Controller

This block sits between a UART serial line and an external 8-bit successive-approximation converter. A host asks for one sample by sending any byte. The block then releases the converter from reset. When the converter reports that it has finished, the block returns the 8-bit result to the host as one serial frame on the transmit line.

The serial link uses 8N1 framing: one start bit, eight data bits with the least significant bit first, no parity bit and one stop bit. The nominal rate is 9600 baud. The bit timing comes from dividing the system clock down to 16 ticks per bit.

One flag carries the whole handshake. The flag rises when a valid byte has been received. It drives the active-low start line of the converter directly, so the converter runs for as long as the flag is high. The converter's active-low completion signal clears the flag and, with the same event, starts the transmission of the result. The block then waits for the next request.

Top module: `adc_serial_sampler`

## Requirements
- R1: The transmitter sends each result as 10 bit periods: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A bit period lasts CLK_HZ/BAUD clock cycles, made of 16 baud ticks, and the first bit may be shorter by at most one tick.
- R2: After reset, `txd` is high and `conv_start_n` is low, which holds the converter in reset.
- R3: Each complete 8N1 byte received while the block is idle raises `conv_start_n`. The value of the byte has no effect on this.
- R4: A start bit is accepted only if the line is still low at the middle of the bit. A low pulse shorter than half a bit period starts no conversion.
- R5: A frame whose stop bit is sampled low is discarded, and `conv_start_n` stays low. After the line returns high, the receiver accepts the next valid frame.
- R6: A falling edge of `conv_done_n`, detected after a two-flop synchronizer while a conversion is pending, captures `conv_data`. The block then transmits that value as one frame.
- R7: The same falling edge of `conv_done_n` drives `conv_start_n` low again, which returns the converter to reset.
- R8: A byte that completes while a conversion is pending or while a result is being transmitted is dropped. It queues no further conversion and no further frame.
- R9: A falling edge of `conv_done_n` while no conversion is pending is ignored, and no frame is transmitted.
- R10: `txd` stays high whenever no frame is being transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line from the host, idle high |
| txd | output | 1 | Serial transmit line to the host, idle high |
| conv_start_n | output | 1 | Converter start line: low holds the converter in reset, and a rising edge starts a conversion |
| conv_done_n | input | 1 | Converter completion signal, asynchronous, active low |
| conv_data | input | 8 | Converter result, captured when completion is detected |

## Verification
The assertions check the following on every cycle:
- the flag rises only after a valid received byte, and only while no result is being sent;
- a completion event clears the flag;
- a load is followed by a start bit;
- the transmit line is high whenever the transmitter is idle;
- baud ticks are never back to back;
- a bad frame never raises the start line.

Only the bench scenarios can show the following:
- that the serial frames carry the correct values at the correct bit timing;
- that the content of a request byte has no effect;
- that bytes arriving during a conversion or a transmission are dropped without being queued;
- that short glitches and bad stop bits are rejected.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // Number of system clocks per oversampling tick, rounded to the nearest value.
  function automatic int unsigned os_divisor(int unsigned clk_hz, int unsigned baud,
                                             int unsigned os);
    int unsigned den;
    den = baud * os;
    return (clk_hz + den / 2) / den;
  endfunction

  // Counter width able to hold the values 0 .. n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/adcs_baud_tick.sv
module adcs_baud_tick
  import adcs_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_843_200,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned OS     = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DIV   = os_divisor(CLK_HZ, BAUD, OS);
  localparam int unsigned DIV_W = cnt_width(DIV);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_count
      logic [DIV_W-1:0] cnt;
      logic             tick_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt    <= '0;
          tick_q <= 1'b0;
        end else if (cnt == DIV_W'(DIV - 1)) begin
          cnt    <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick = tick_q;

      // R1: ticks are isolated single-cycle pulses
      p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/adcs_uart_rx.sv
module adcs_uart_rx
  import adcs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OS     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic byte_ok,
  output logic frame_err
);
  localparam int unsigned OS_W  = cnt_width(OS);
  localparam int unsigned IDX_W = cnt_width(DATA_W);
  localparam int unsigned HALF  = OS / 2;

  logic            rx_q1, rx_s;
  rx_state_e       state;
  logic [OS_W-1:0] os_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic            os_last;
  logic            os_mid;

  assign os_last = (os_cnt == OS_W'(OS - 1));
  assign os_mid  = (os_cnt == OS_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_q1 <= rxd;
      rx_s  <= rx_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      bit_idx   <= '0;
      byte_ok   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_ok   <= 1'b0;
      frame_err <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (!rx_s) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (os_mid) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (os_last) begin
              os_cnt <= '0;
              if (bit_idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (os_last) begin
              os_cnt <= '0;
              if (rx_s) begin
                byte_ok <= 1'b1;
                state   <= RX_IDLE;
              end else begin
                frame_err <= 1'b1;
                state     <= RX_HOLD;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R5: a frame ends either valid or discarded, never both
  p_ok_err_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_ok && frame_err));
  // R5: a discarded frame is not followed by a completion in the next cycle
  p_err_no_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !byte_ok);
endmodule

// File: rtl/adcs_uart_tx.sv
module adcs_uart_tx
  import adcs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              busy
);
  localparam int unsigned OS_W  = cnt_width(OS);
  localparam int unsigned BIT_W = cnt_width(DATA_W + 2);

  logic [DATA_W:0]  sh;
  logic [OS_W-1:0]  os_cnt;
  logic [BIT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      os_cnt  <= '0;
      bit_cnt <= '0;
      txd     <= 1'b1;
      busy    <= 1'b0;
    end else if (load && !busy) begin
      sh      <= {1'b1, data};
      os_cnt  <= '0;
      bit_cnt <= '0;
      txd     <= 1'b0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (os_cnt == OS_W'(OS - 1)) begin
        os_cnt <= '0;
        if (bit_cnt == BIT_W'(DATA_W + 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd     <= sh[0];
          sh      <= {1'b1, sh[DATA_W:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end

  // R10: the line idles high
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R8: no load is issued over a frame in flight
  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/adcs_conv_ctrl.sv
module adcs_conv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_byte_ok,
  input  logic done_n,
  input  logic tx_busy,
  output logic start_n,
  output logic tx_load,
  output logic done_evt
);
  logic done_q1, done_s, done_prev;
  logic req_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q1   <= 1'b1;
      done_s    <= 1'b1;
      done_prev <= 1'b1;
    end else begin
      done_q1   <= done_n;
      done_s    <= done_q1;
      done_prev <= done_s;
    end
  end

  assign done_evt = done_prev && !done_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_flag <= 1'b0;
    end else if (done_evt && req_flag) begin
      req_flag <= 1'b0;
    end else if (rx_byte_ok && !req_flag && !tx_busy) begin
      req_flag <= 1'b1;
    end
  end

  assign start_n = req_flag;
  assign tx_load = done_evt && req_flag;

  // R3: the flag rises only after a valid received byte
  p_set_on_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag) |-> $past(rx_byte_ok));
  // R8: the flag never rises while a result is in flight
  p_no_set_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag) |-> !$past(tx_busy));
  // R7: completion returns the converter to reset
  p_clear_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && req_flag) |=> !req_flag);
endmodule

// File: rtl/adc_serial_sampler.sv
module adc_serial_sampler #(
  parameter int unsigned CLK_HZ = 1_843_200,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned OS     = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              txd,
  output logic              conv_start_n,
  input  logic              conv_done_n,
  input  logic [DATA_W-1:0] conv_data
);
  logic tick;
  logic rx_byte_ok;
  logic rx_frame_err;
  logic tx_load;
  logic tx_busy;
  logic done_evt;

  adcs_baud_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OS(OS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  adcs_uart_rx #(.DATA_W(DATA_W), .OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .byte_ok(rx_byte_ok), .frame_err(rx_frame_err)
  );

  adcs_conv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_byte_ok(rx_byte_ok), .done_n(conv_done_n),
    .tx_busy(tx_busy), .start_n(conv_start_n), .tx_load(tx_load), .done_evt(done_evt)
  );

  adcs_uart_tx #(.DATA_W(DATA_W), .OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .data(conv_data),
    .txd(txd), .busy(tx_busy)
  );

  // R6: a captured result starts with a low start bit
  p_load_starts_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!txd && tx_busy));
  // R9: with no conversion pending, completion never starts a frame
  p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !conv_start_n && !tx_busy) |=> !tx_busy);
  // R5: a discarded frame does not start a conversion
  p_bad_frame_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_err && !conv_start_n) |=> !conv_start_n);
endmodule

// File: tb/tb_adc_serial_sampler.sv
module tb_adc_serial_sampler;
  localparam int unsigned CLK_HZ = 1_843_200;
  localparam int unsigned BAUD   = 9600;
  localparam int          BIT    = CLK_HZ / BAUD;      // 192 cycles per bit
  localparam int          TICK   = BIT / 16;           // 12 cycles per tick
  localparam int          FRAME  = 10 * BIT;
  localparam int          LIMIT  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic       conv_start_n;
  logic       conv_done_n;
  logic [7:0] conv_data = 8'h00;
  logic       model_done_n = 1'b1;
  logic       stray_done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int conv_starts = 0;
  int frames_got = 0;
  int conv_delay = 200;
  int conv_index = 0;
  bit run_clock_cmp = 1'b0;
  logic [7:0] exp_q[$];

  assign conv_done_n = model_done_n & ~stray_done;

  always #2.5 clk = ~clk;

  adc_serial_sampler #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
    .conv_start_n(conv_start_n), .conv_done_n(conv_done_n), .conv_data(conv_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Host side: one serial frame, LSB first, with a selectable stop level.
  task automatic send_frame(input logic [7:0] b, input logic stop_lvl);
    rxd = 1'b0;
    wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_cyc(BIT);
    end
    rxd = stop_lvl;
    wait_cyc(BIT);
    rxd = 1'b1;
  endtask

  task automatic wait_frames(input int n, input string req);
    int t;
    t = 0;
    while (frames_got < n && t < 4 * FRAME) begin
      @(negedge clk);
      t++;
    end
    chk(frames_got >= n, req, frames_got, n);
  endtask

  // Watchdog
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, LIMIT);
        summary_and_end();
      end
    end
  end

  // Behavioural converter: rising start begins a conversion, completion stays
  // low until the start line returns low.
  initial begin
    forever begin
      @(posedge conv_start_n);
      conv_starts++;
      wait_cyc(conv_delay);
      conv_data = 8'hA5 ^ 8'(conv_index * 37);
      conv_index++;
      exp_q.push_back(conv_data);
      model_done_n = 1'b0;
      wait (conv_start_n == 1'b0);
      @(negedge clk);
      model_done_n = 1'b1;
    end
  end

  // Host serial decoder for the result frames (R1, R6, R9).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        logic [7:0] b;
        int low_len;
        low_len = 1;
        repeat (BIT / 2) begin
          @(negedge clk);
          if (txd == 1'b0 && low_len > 0) low_len++;
          else low_len = -low_len;
        end
        chk(txd == 1'b0, "R1 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) begin
            @(negedge clk);
            if (low_len > 0) begin
              if (txd == 1'b0) low_len++;
              else low_len = -low_len;
            end
          end
          b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        chk(txd == 1'b1, "R1 stop bit", txd, 1);
        if (b[0]) begin
          chk((-low_len) >= BIT - TICK && (-low_len) <= BIT + 1, "R1 bit period",
              -low_len, BIT);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected frame", b, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(b == e, "R6 result value", b, e);
        end
        frames_got++;
      end
    end
  end

  // Per-clock comparison with the model: the line is low only when a result is owed.
  initial begin
    forever begin
      @(negedge clk);
      if (run_clock_cmp) begin
        n_cmp++;
        if (txd == 1'b0 && exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R10 idle line actual=%0b expected=1 at cycle %0d", txd, cycles);
        end
      end
    end
  end

  initial begin
    int base_starts;
    int base_frames;

    wait_cyc(10);
    chk(txd == 1'b1, "R2 txd reset", txd, 1);
    chk(conv_start_n == 1'b0, "R2 start reset", conv_start_n, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    run_clock_cmp = 1'b1;

    // R3/R6/R7: basic request with a zero byte
    conv_delay = 200;
    send_frame(8'h00, 1'b1);
    wait_cyc(2);
    chk(conv_start_n == 1'b1, "R3 start after 0x00", conv_start_n, 1);
    wait_frames(1, "R6 first frame");
    chk(conv_start_n == 1'b0, "R7 start cleared", conv_start_n, 0);
    wait_cyc(BIT);

    // R3: request value has no effect
    send_frame(8'hFF, 1'b1);
    wait_cyc(2);
    chk(conv_start_n == 1'b1, "R3 start after 0xFF", conv_start_n, 1);
    wait_frames(2, "R6 second frame");
    wait_cyc(BIT);
    send_frame(8'h3C, 1'b1);
    wait_cyc(2);
    chk(conv_start_n == 1'b1, "R3 start after 0x3C", conv_start_n, 1);
    wait_frames(3, "R6 third frame");
    wait_cyc(BIT);

    // R8: byte during a pending conversion is dropped
    conv_delay = 2500;
    base_starts = conv_starts;
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    wait_frames(4, "R6 frame after drop");
    wait_cyc(3 * BIT);
    chk(conv_starts == base_starts + 1, "R8 drop during conversion", conv_starts,
        base_starts + 1);
    chk(frames_got == 4, "R8 no queued frame", frames_got, 4);
    chk(conv_start_n == 1'b0, "R8 start low after drop", conv_start_n, 0);

    // R8: byte during transmission is dropped
    conv_delay = 200;
    base_starts = conv_starts;
    send_frame(8'h33, 1'b1);
    wait (conv_start_n == 1'b0);
    @(negedge clk);
    send_frame(8'h44, 1'b1);
    wait_frames(5, "R6 frame during tx drop");
    wait_cyc(3 * BIT);
    chk(conv_starts == base_starts + 1, "R8 drop during tx", conv_starts, base_starts + 1);
    chk(frames_got == 5, "R8 no second frame", frames_got, 5);

    // R5: low stop bit discards the frame, then recovery
    base_starts = conv_starts;
    send_frame(8'h55, 1'b0);
    wait_cyc(2 * BIT);
    chk(conv_start_n == 1'b0, "R5 bad stop ignored", conv_start_n, 0);
    chk(conv_starts == base_starts, "R5 no conversion", conv_starts, base_starts);
    send_frame(8'h66, 1'b1);
    wait_cyc(2);
    chk(conv_start_n == 1'b1, "R5 recovery start", conv_start_n, 1);
    wait_frames(6, "R6 frame after recovery");
    wait_cyc(BIT);

    // R4: short low glitch is not a start bit
    rxd = 1'b0;
    wait_cyc(BIT / 4);
    rxd = 1'b1;
    wait_cyc(2 * BIT);
    chk(conv_start_n == 1'b0, "R4 glitch ignored", conv_start_n, 0);

    // R9: stray completion with nothing pending
    base_frames = frames_got;
    stray_done = 1'b1;
    wait_cyc(20);
    stray_done = 1'b0;
    wait_cyc(3 * BIT);
    chk(frames_got == base_frames, "R9 no frame on stray done", frames_got, base_frames);
    chk(txd == 1'b1, "R10 line idle high", txd, 1);
    chk(conv_start_n == 1'b0, "R9 start stays low", conv_start_n, 0);

    // Final request still works after the stray event
    send_frame(8'h80, 1'b1);
    wait_frames(7, "R6 final frame");
    wait_cyc(BIT);
    chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);

    run_clock_cmp = 1'b0;
    summary_and_end();
  end
endmodule